// File: doc/BRIEF.md
# PWM Period and High-Time Meter

This block measures one pulse-width-modulated signal that arrives on a single input pin. A counter runs from the internal clock through a programmable prescaler. The pin feeds two capture channels. The first channel watches one edge polarity and the second watches the opposite one. In the usual setup the first channel latches the counter on each rising edge, and that same edge restarts the counter from zero. The first capture register therefore holds the period and the second holds the high time. Software reads both values with no subtraction.

The configuration arrives as plain level inputs that would normally come from control registers: a source select, a polarity and a capture enable for each channel, plus a trigger select, a slave mode and the prescaler value. Each channel also has a sticky capture flag, an overcapture flag and a clear strobe.

Top module: `pwm_meas_top`

## Requirements
- R1: After reset both capture values are 0 and all four flags are 0.
- R2: Channel 1 captures only when its select is 2'b01. On its active edge it loads the counter value held just before that edge's clock. With any other select value, channel 1 never captures.
- R3: Channel 2 captures only when its select is 2'b10, from the same pin. With any other select value, channel 2 never captures.
- R4: When the trigger select is 3'b101 and the slave mode is 3'b100, the channel 1 edge sets the counter and the prescaler to 0 on the next clock. With any other trigger select or slave mode, the counter runs freely.
- R5: The counter advances once every psc+1 clocks.
- R6: Use polarity 0 on channel 1 (rising edge), polarity 1 on channel 2 (falling edge), trigger 3'b101 and slave mode 3'b100. For a steady PWM of period P clocks and high time H clocks, cap1 = floor((P-1)/(psc+1)) and cap2 = floor((H-1)/(psc+1)).
- R7: With a channel's enable at 0, its capture value and flag do not change. The channel 1 edge still resets the counter even when channel 1 is disabled.
- R8: A capture sets the channel's flag. The clear strobe resets the flag. If a capture and a clear arrive in the same cycle, the flag is set.
- R9: A capture that arrives while the flag is already set, with no clear in that cycle, sets the overcapture flag. The overcapture flag stays set until a clear.
- R10: With channel 1 polarity 1 and channel 2 polarity 0, and the other settings as in R6, cap1 = floor((P-1)/(psc+1)) and cap2 = floor((P-H-1)/(psc+1)).
- R11: In free-running mode the counter wraps modulo 2^CNT_W. Captures taken P clocks apart with psc=0 differ by P mod 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous PWM input |
| ch1_sel | input | 2 | Channel 1 source select (01 = pin direct path) |
| ch1_pol | input | 1 | Channel 1 polarity (0 rising, 1 falling) |
| ch1_en | input | 1 | Channel 1 capture enable |
| ch2_sel | input | 2 | Channel 2 source select (10 = pin cross path) |
| ch2_pol | input | 1 | Channel 2 polarity (0 rising, 1 falling) |
| ch2_en | input | 1 | Channel 2 capture enable |
| trig_sel | input | 3 | Trigger select (101 = channel 1 path) |
| slave_mode | input | 3 | Slave mode (100 = counter reset) |
| psc | input | PSC_W | Prescaler, ticks every psc+1 clocks |
| ch1_clr | input | 1 | Clears channel 1 flags |
| ch2_clr | input | 1 | Clears channel 2 flags |
| cap1_val | output | CNT_W | Channel 1 capture value (period) |
| cap1_flag | output | 1 | Channel 1 capture flag |
| cap1_ovr | output | 1 | Channel 1 overcapture flag |
| cap2_val | output | CNT_W | Channel 2 capture value (high time) |
| cap2_flag | output | 1 | Channel 2 capture flag |
| cap2_ovr | output | 1 | Channel 2 overcapture flag |

## Verification
The bench builds the block with CNT_W=8 and PSC_W=2. The 2-bit prescaler allows every prescaler value from 0 to 3 to be swept against every period from 2 to 12 clocks and every high time inside each period. The 8-bit counter lets a free-running capture pair 300 clocks apart show the wrap within a few hundred cycles. The bench also covers swapped polarities, wrong source selects and disabled channels, and it compares each result with values worked out arithmetically.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;

    localparam logic [1:0] SEL_DIRECT = 2'b01;
    localparam logic [1:0] SEL_CROSS  = 2'b10;
    localparam logic [2:0] TRIG_PATH1 = 3'b101;
    localparam logic [2:0] SLV_RESET  = 3'b100;
    localparam int         NUM_CH     = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic [1:0] sel;
        logic       pol;
        logic       en;
        logic       clr;
    } chan_cfg_t;

    function automatic logic pick_edge(input edge_t e, input logic pol);
        return pol ? e.fall : e.rise;
    endfunction

    function automatic logic [1:0] wanted_sel(input int idx);
        return (idx == 0) ? SEL_DIRECT : SEL_CROSS;
    endfunction

endpackage

// File: rtl/pwm_in_sync.sv
module pwm_in_sync
    import pwm_meas_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output edge_t edges
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], pin};
        end
    end

    always_comb begin
        edges.rise = shreg[STAGES-1] & ~shreg[STAGES];
        edges.fall = ~shreg[STAGES-1] & shreg[STAGES];
    end
endmodule

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PSC_W-1:0] psc,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    logic [PSC_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (restart) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (div_q >= psc) begin
            div_q <= '0;
            cnt   <= cnt + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_cap_chan.sv
module pwm_cap_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             en,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] val,
    output logic             flag,
    output logic             ovr
);
    logic hit;
    assign hit = evt & en;

    always_ff @(posedge clk) begin
        if (rst) begin
            val  <= '0;
            flag <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (hit) begin
                val <= cnt;
            end
            if (hit) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
            if (hit && flag && !clr) begin
                ovr <= 1'b1;
            end else if (clr) begin
                ovr <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwm_meas_top.sv
module pwm_meas_top
    import pwm_meas_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_in,
    input  logic [1:0]       ch1_sel,
    input  logic             ch1_pol,
    input  logic             ch1_en,
    input  logic [1:0]       ch2_sel,
    input  logic             ch2_pol,
    input  logic             ch2_en,
    input  logic [2:0]       trig_sel,
    input  logic [2:0]       slave_mode,
    input  logic [PSC_W-1:0] psc,
    input  logic             ch1_clr,
    input  logic             ch2_clr,
    output logic [CNT_W-1:0] cap1_val,
    output logic             cap1_flag,
    output logic             cap1_ovr,
    output logic [CNT_W-1:0] cap2_val,
    output logic             cap2_flag,
    output logic             cap2_ovr
);
    edge_t            edges;
    logic [CNT_W-1:0] cnt_q;
    logic             trig_evt;
    logic             cnt_restart;
    chan_cfg_t        cfg     [NUM_CH];
    logic [NUM_CH-1:0] cap_evt;
    logic [CNT_W-1:0] val     [NUM_CH];
    logic [NUM_CH-1:0] flag;
    logic [NUM_CH-1:0] ovr;

    assign cfg[0] = '{sel: ch1_sel, pol: ch1_pol, en: ch1_en, clr: ch1_clr};
    assign cfg[1] = '{sel: ch2_sel, pol: ch2_pol, en: ch2_en, clr: ch2_clr};

    pwm_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .pin   (pin_in),
        .edges (edges)
    );

    assign trig_evt    = (trig_sel == TRIG_PATH1) && pick_edge(edges, ch1_pol);
    assign cnt_restart = trig_evt && (slave_mode == SLV_RESET);

    pwm_tick_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) ctr_i (
        .clk     (clk),
        .rst     (rst),
        .psc     (psc),
        .restart (cnt_restart),
        .cnt     (cnt_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign cap_evt[g] = (cfg[g].sel == wanted_sel(g)) && pick_edge(edges, cfg[g].pol);

        pwm_cap_chan #(.CNT_W(CNT_W)) chan_i (
            .clk  (clk),
            .rst  (rst),
            .evt  (cap_evt[g]),
            .en   (cfg[g].en),
            .clr  (cfg[g].clr),
            .cnt  (cnt_q),
            .val  (val[g]),
            .flag (flag[g]),
            .ovr  (ovr[g])
        );
    end

    assign cap1_val  = val[0];
    assign cap1_flag = flag[0];
    assign cap1_ovr  = ovr[0];
    assign cap2_val  = val[1];
    assign cap2_flag = flag[1];
    assign cap2_ovr  = ovr[1];
endmodule

// File: rtl/pwm_meas_chk.sv
module pwm_meas_chk #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [PSC_W-1:0] psc,
    input logic             cnt_restart,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       cap_evt,
    input logic             ch1_en,
    input logic             ch2_en,
    input logic             ch1_clr,
    input logic             ch2_clr,
    input logic [CNT_W-1:0] cap1_val,
    input logic             cap1_flag,
    input logic             cap1_ovr,
    input logic [CNT_W-1:0] cap2_val,
    input logic             cap2_flag,
    input logic             cap2_ovr
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_restart |=> cnt_q == '0);

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        !cnt_restart |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE));

    p_psc0_step_r5: assert property (@(posedge clk) disable iff (rst)
        (psc == '0 && !cnt_restart) |=> cnt_q == $past(cnt_q) + ONE);

    p_ch1_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (cap_evt[0] && ch1_en) |=> cap1_val == $past(cnt_q));

    p_ch2_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_evt[1] && ch2_en) |=> cap2_val == $past(cnt_q));

    p_ch1_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!ch1_en && !ch1_clr) |=> $stable(cap1_val) && $stable(cap1_flag));

    p_ch2_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!ch2_en && !ch2_clr) |=> $stable(cap2_val) && $stable(cap2_flag));

    p_ch1_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (cap_evt[0] && ch1_en) |=> cap1_flag);

    p_ch2_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (cap_evt[1] && ch2_en) |=> cap2_flag);

    p_ch1_ovr_set_r9: assert property (@(posedge clk) disable iff (rst)
        (cap_evt[0] && ch1_en && cap1_flag && !ch1_clr) |=> cap1_ovr);

    p_ch1_ovr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cap1_ovr && !ch1_clr) |=> cap1_ovr);

    p_ch1_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ch1_clr && !(cap_evt[0] && ch1_en)) |=> !cap1_flag && !cap1_ovr);

    p_ch2_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ch2_clr && !(cap_evt[1] && ch2_en)) |=> !cap2_flag && !cap2_ovr);

    p_ch2_ovr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cap2_ovr && !ch2_clr) |=> cap2_ovr);
endmodule

bind pwm_meas_top pwm_meas_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .psc         (psc),
    .cnt_restart (cnt_restart),
    .cnt_q       (cnt_q),
    .cap_evt     (cap_evt),
    .ch1_en      (ch1_en),
    .ch2_en      (ch2_en),
    .ch1_clr     (ch1_clr),
    .ch2_clr     (ch2_clr),
    .cap1_val    (cap1_val),
    .cap1_flag   (cap1_flag),
    .cap1_ovr    (cap1_ovr),
    .cap2_val    (cap2_val),
    .cap2_flag   (cap2_flag),
    .cap2_ovr    (cap2_ovr)
);

// File: tb/pwm_meas_top_tb_top.sv
module pwm_meas_top_tb_top;
    localparam int CNT_W = 8;
    localparam int PSC_W = 2;
    localparam int MASK  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_in = 1'b0;
    logic [1:0] ch1_sel = 2'b01;
    logic ch1_pol = 1'b0;
    logic ch1_en = 1'b1;
    logic [1:0] ch2_sel = 2'b10;
    logic ch2_pol = 1'b1;
    logic ch2_en = 1'b1;
    logic [2:0] trig_sel = 3'b101;
    logic [2:0] slave_mode = 3'b100;
    logic [PSC_W-1:0] psc = '0;
    logic ch1_clr = 1'b0;
    logic ch2_clr = 1'b0;
    logic [CNT_W-1:0] cap1_val, cap2_val;
    logic cap1_flag, cap1_ovr, cap2_flag, cap2_ovr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pwm_meas_top #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .ch1_sel(ch1_sel), .ch1_pol(ch1_pol), .ch1_en(ch1_en),
        .ch2_sel(ch2_sel), .ch2_pol(ch2_pol), .ch2_en(ch2_en),
        .trig_sel(trig_sel), .slave_mode(slave_mode), .psc(psc),
        .ch1_clr(ch1_clr), .ch2_clr(ch2_clr),
        .cap1_val(cap1_val), .cap1_flag(cap1_flag), .cap1_ovr(cap1_ovr),
        .cap2_val(cap2_val), .cap2_flag(cap2_flag), .cap2_ovr(cap2_ovr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic drive(input int per, input int hi, input int n);
        for (int i = 0; i < n; i++) begin
            pin_in = 1'b1;
            repeat (hi) @(negedge clk);
            pin_in = 1'b0;
            repeat (per - hi) @(negedge clk);
        end
    endtask

    task automatic clear_flags();
        ch1_clr = 1'b1;
        ch2_clr = 1'b1;
        @(negedge clk);
        ch1_clr = 1'b0;
        ch2_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int a1, a2;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cap1_val", int'(cap1_val), 0);
        chk("R1 cap2_val", int'(cap2_val), 0);
        chk("R1 flags", int'({cap1_flag, cap1_ovr, cap2_flag, cap2_ovr}), 0);

        // R5 R6 R8 R9: sweep every prescaler, period and high time
        for (int p = 0; p < 4; p++) begin
            for (int per = 2; per <= 12; per++) begin
                for (int hi = 1; hi < per; hi++) begin
                    psc = PSC_W'(p);
                    idle(4);
                    clear_flags();
                    drive(per, hi, 3);
                    idle(4);
                    chk("R6 R5 period", int'(cap1_val), (per - 1) / (p + 1));
                    chk("R6 R5 high time", int'(cap2_val), (hi - 1) / (p + 1));
                    chk("R8 flags set", int'({cap1_flag, cap2_flag}), 3);
                    chk("R9 overcapture set", int'({cap1_ovr, cap2_ovr}), 3);
                    clear_flags();
                    chk("R8 R9 cleared", int'({cap1_flag, cap1_ovr, cap2_flag, cap2_ovr}), 0);
                end
            end
        end

        // R7: channel 1 disabled, trigger still resets the counter
        psc = '0;
        ch1_en = 1'b0;
        idle(4);
        clear_flags();
        a1 = int'(cap1_val);
        drive(10, 3, 3);
        idle(4);
        chk("R7 cap1 held", int'(cap1_val), a1);
        chk("R7 cap1 flag", int'(cap1_flag), 0);
        chk("R7 cap2 with trigger", int'(cap2_val), 2);
        ch1_en = 1'b1;
        ch2_en = 1'b0;
        clear_flags();
        a2 = int'(cap2_val);
        drive(9, 5, 3);
        idle(4);
        chk("R7 cap2 held", int'(cap2_val), a2);
        chk("R7 cap2 flag", int'(cap2_flag), 0);
        chk("R7 cap1 live", int'(cap1_val), 8);
        ch2_en = 1'b1;

        // R2 R3: wrong source selects never capture
        for (int s = 0; s < 2; s++) begin
            ch1_sel = (s == 0) ? 2'b00 : 2'b11;
            ch2_sel = (s == 0) ? 2'b01 : 2'b11;
            idle(4);
            clear_flags();
            a1 = int'(cap1_val);
            a2 = int'(cap2_val);
            drive(9, 4, 3);
            idle(4);
            chk("R2 cap1 unchanged", int'(cap1_val), a1);
            chk("R2 cap1 flag", int'(cap1_flag), 0);
            chk("R3 cap2 unchanged", int'(cap2_val), a2);
            chk("R3 cap2 flag", int'(cap2_flag), 0);
        end
        ch1_sel = 2'b01;
        ch2_sel = 2'b10;

        // R10: swapped polarities measure period and low time
        ch1_pol = 1'b1;
        ch2_pol = 1'b0;
        for (int p = 0; p < 4; p++) begin
            psc = PSC_W'(p);
            idle(4);
            drive(11, 3, 3);
            idle(4);
            chk("R10 period", int'(cap1_val), 10 / (p + 1));
            chk("R10 low time", int'(cap2_val), 7 / (p + 1));
        end
        ch1_pol = 1'b0;
        ch2_pol = 1'b1;
        psc = '0;

        // R4 R11: free running with wrap, two ways of disabling reset
        for (int m = 0; m < 2; m++) begin
            if (m == 0) begin
                slave_mode = 3'b000;
                trig_sel   = 3'b101;
            end else begin
                slave_mode = 3'b100;
                trig_sel   = 3'b000;
            end
            idle(4);
            drive(300, 120, 1);
            a1 = int'(cap1_val);
            a2 = int'(cap2_val);
            drive(300, 120, 1);
            chk("R4 R11 cap1 step", (int'(cap1_val) - a1) & MASK, 300 & MASK);
            chk("R4 R11 cap2 step", (int'(cap2_val) - a2) & MASK, 300 & MASK);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule